// File: doc/BRIEF.md
# Full-Duplex Serial Shift Engine with Latched Error Flags

This block moves one character at a time over a four-wire serial link in clock mode 0 (clock idles low, data is sampled on the rising clock edge and changed on the falling edge). As a master it makes the serial clock from the system clock. As a slave it follows an external clock while an active-low select input is held low. A configuration input picks 8-bit or 16-bit characters at run time. In the 8-bit mode only the low byte of the 16-bit data word is sent or received. Characters are sent most significant bit first.

Software writes a 16-bit data word to start a master transfer, or to stage the word a slave sends at its next selection. Received characters pass from the shift register into a separate read buffer, so software has one full character time to fetch each result. Three status flags (read buffer full, receive overrun and write collision) are each ANDed with an enable bit and then ORed into one interrupt line. The two error flags are sticky, and a flag-write strobe can set or clear them.

Top module: `spi_xfer_engine`

## Requirements
- R1: With `cfg_wide`=0 a transfer is 8 clock pulses long. With `cfg_wide`=1 it is 16 pulses. Bits go out and come in most significant bit first.
- R2: In 8-bit mode the character sent is bits [7:0] of the written word. Bits [15:8] have no effect on the serial output.
- R3: In 8-bit mode the received byte appears in `rd_data[7:0]` and `rd_data[15:8]` reads as zero.
- R4: When a character completes, it is copied into the read buffer and `flags[0]` (buffer full) is set. A cycle with `rd_en` high clears `flags[0]`. `rd_data` always shows the buffer contents.
- R5: If a character completes while `flags[0]` is set and `rd_en` is low, the buffer is overwritten and `flags[1]` (overrun) is set. If `rd_en` is high in the completion cycle, the old word is consumed, the new word is stored and no overrun is flagged.
- R6: A write while `busy` is high sets `flags[2]` (write collision). The transfer in progress continues unchanged, and the rejected word is not stored for later sending.
- R7: `flags[1]` and `flags[2]` stay set until reset or a flag write. A flag write loads `flags[1]` from `err_wr_data[0]` and `flags[2]` from `err_wr_data[1]`. A hardware set in the same cycle takes priority.
- R8: `irq` is high whenever some `flags[i]` and `irq_en[i]` are both high, including when a flag was set by software.
- R9: In master mode `busy` rises in the cycle after an accepted write and falls at the falling edge of the last clock pulse. The clock pulse high and low phases each last `SCK_DIV` system cycles, and `sck_o` is low whenever `busy` is low.
- R10: In slave mode the staged word is loaded when `sel_n_i` goes low. The block samples `spi_din` on rising `sck_i` edges and changes `spi_dout` on falling edges. Raising `sel_n_i` early abandons the character.
- R11: After reset `busy`, `flags`, `irq`, `sck_o` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_wide | input | 1 | 0 selects 8-bit characters, 1 selects 16-bit characters |
| wr_en | input | 1 | Data word write strobe |
| wr_data | input | 16 | Data word to send |
| rd_en | input | 1 | Read strobe; marks the read buffer empty |
| rd_data | output | 16 | Read buffer contents |
| err_wr_en | input | 1 | Error flag write strobe |
| err_wr_data | input | 2 | Bit 0 goes to overrun, bit 1 goes to write collision |
| irq_en | input | 3 | Interrupt enable for each bit of `flags` |
| busy | output | 1 | Transfer in progress |
| flags | output | 3 | Bit 0 buffer full, bit 1 overrun, bit 2 write collision |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| sel_n_i | input | 1 | Active-low select in slave mode |
| spi_din | input | 1 | Serial data in (master in / slave in, depending on mode) |
| spi_dout | output | 1 | Serial data out |

## Verification
A software read and the completion of the next character can land in the same system cycle. The block must then hand the old word to software, store the new one and leave the overrun flag clear. The bench provokes this by counting master clock pulses and raising `rd_en` for exactly the cycle of the last falling clock edge. It then checks that the word read is the old one, that the buffer holds the new one and that `flags[1]` is still low. A contrasting run with no read in that cycle must set the overrun flag and leave the newer character in the buffer.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int WORD_W  = 16;
    localparam int BYTE_W  = WORD_W / 2;
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int NUM_FLG = 3;

    localparam int FLG_RXF  = 0;
    localparam int FLG_ROVR = 1;
    localparam int FLG_WCOL = 2;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [NUM_FLG-1:0] flag_vec_t;
    typedef logic [CNT_W-1:0]   bitcnt_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_ev_t;

    // index of the last bit of a character
    function automatic bitcnt_t last_bit(input logic wide);
        return wide ? bitcnt_t'(WORD_W - 1) : bitcnt_t'(BYTE_W - 1);
    endfunction

    // right-justify a narrow character and zero the unused upper byte
    function automatic word_t rx_justify(input word_t w, input logic wide);
        return wide ? w : {{(WORD_W - BYTE_W){1'b0}}, w[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spi_xfer_pkg::*;
#(
    parameter int SCK_DIV = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    master,
    input  logic    run,
    input  logic    sck_i,
    input  logic    sel_n_i,
    output sck_ev_t ev,
    output logic    sck_o,
    output logic    sel_act,
    output logic    sel_start
);
    localparam int DIV_W = $clog2(SCK_DIV) + 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_DIV - 1);

    logic [DIV_W-1:0] cnt;
    logic             sck_q;
    logic [2:0]       sck_sync;
    logic [2:0]       sel_sync;
    logic             tick;
    sck_ev_t          m_ev, s_ev;

    assign tick = run && (cnt == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            sck_q    <= 1'b0;
            sck_sync <= '0;
            sel_sync <= '1;
        end else begin
            if (!run) begin
                cnt   <= '0;
                sck_q <= 1'b0;
            end else if (tick) begin
                cnt   <= '0;
                sck_q <= ~sck_q;
            end else begin
                cnt <= cnt + 1'b1;
            end
            sck_sync <= {sck_sync[1:0], sck_i};
            sel_sync <= {sel_sync[1:0], sel_n_i};
        end
    end

    assign sel_act   = !sel_sync[1];
    assign sel_start = !sel_sync[1] && sel_sync[2];

    always_comb begin
        m_ev.rise = tick && !sck_q;
        m_ev.fall = tick && sck_q;
        s_ev.rise = sel_act && sck_sync[1] && !sck_sync[2];
        s_ev.fall = sel_act && !sck_sync[1] && sck_sync[2];
        ev        = master ? m_ev : s_ev;
    end

    assign sck_o = sck_q;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_xfer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wide,
    input  sck_ev_t ev,
    input  logic    start,
    input  logic    abort,
    input  word_t   load_word,
    input  logic    din,
    output logic    busy,
    output logic    dout,
    output logic    done,
    output word_t   rx_word
);
    word_t   sh;
    logic    samp;
    bitcnt_t bcnt;
    logic    at_last;

    assign at_last = (bcnt == last_bit(wide));
    assign done    = busy && !abort && ev.fall && at_last;
    assign rx_word = rx_justify({sh[WORD_W-2:0], samp}, wide);
    assign dout    = wide ? sh[WORD_W-1] : sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '0;
            samp <= 1'b0;
            bcnt <= '0;
        end else if (start) begin
            busy <= 1'b1;
            sh   <= load_word;
            bcnt <= '0;
        end else if (busy) begin
            if (abort) begin
                busy <= 1'b0;
            end else if (ev.rise) begin
                samp <= din;
            end else if (ev.fall) begin
                sh <= {sh[WORD_W-2:0], samp};
                if (at_last) busy <= 1'b0;
                else         bcnt <= bcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank
    import spi_xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      done,
    input  word_t     rx_word,
    input  logic      rd_en,
    input  logic      collide,
    input  logic      err_wr_en,
    input  logic [1:0] err_wr_data,
    input  flag_vec_t irq_en,
    output word_t     rd_data,
    output flag_vec_t flags,
    output logic      irq
);
    word_t rx_buf;
    logic  rx_full, rovr, wcol;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
            rovr    <= 1'b0;
            wcol    <= 1'b0;
        end else begin
            if (done) begin
                rx_buf  <= rx_word;
                rx_full <= 1'b1;
            end else if (rd_en) begin
                rx_full <= 1'b0;
            end

            if (done && rx_full && !rd_en) rovr <= 1'b1;
            else if (err_wr_en)            rovr <= err_wr_data[0];

            if (collide)        wcol <= 1'b1;
            else if (err_wr_en) wcol <= err_wr_data[1];
        end
    end

    always_comb begin
        flags           = '0;
        flags[FLG_RXF]  = rx_full;
        flags[FLG_ROVR] = rovr;
        flags[FLG_WCOL] = wcol;
    end

    assign rd_data = rx_buf;
    assign irq     = |(flags & irq_en);

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int SCK_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_master,
    input  logic        cfg_wide,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    input  logic        err_wr_en,
    input  logic [1:0]  err_wr_data,
    input  logic [2:0]  irq_en,
    output logic        busy,
    output logic [2:0]  flags,
    output logic        irq,
    output logic        sck_o,
    input  logic        sck_i,
    input  logic        sel_n_i,
    input  logic        spi_din,
    output logic        spi_dout
);
    sck_ev_t ev;
    logic    sel_act, sel_start;
    logic    start_m, start_s, abort_s, xfer_start, xfer_done;
    word_t   tx_q, load_word, rx_word;

    assign start_m    = wr_en && cfg_master && !busy;
    assign start_s    = !cfg_master && sel_start && !busy;
    assign abort_s    = !cfg_master && !sel_act;
    assign xfer_start = start_m || start_s;
    assign load_word  = cfg_master ? wr_data : tx_q;

    // staged word: only writes outside a transfer are accepted
    always_ff @(posedge clk) begin
        if (rst)                 tx_q <= '0;
        else if (wr_en && !busy) tx_q <= wr_data;
    end

    spi_sck_gen #(.SCK_DIV(SCK_DIV)) u_sck (
        .clk      (clk),
        .rst      (rst),
        .master   (cfg_master),
        .run      (busy && cfg_master),
        .sck_i    (sck_i),
        .sel_n_i  (sel_n_i),
        .ev       (ev),
        .sck_o    (sck_o),
        .sel_act  (sel_act),
        .sel_start(sel_start)
    );

    spi_shift_core u_core (
        .clk      (clk),
        .rst      (rst),
        .wide     (cfg_wide),
        .ev       (ev),
        .start    (xfer_start),
        .abort    (abort_s),
        .load_word(load_word),
        .din      (spi_din),
        .busy     (busy),
        .dout     (spi_dout),
        .done     (xfer_done),
        .rx_word  (rx_word)
    );

    spi_flag_bank u_flags (
        .clk        (clk),
        .rst        (rst),
        .done       (xfer_done),
        .rx_word    (rx_word),
        .rd_en      (rd_en),
        .collide    (wr_en && busy),
        .err_wr_en  (err_wr_en),
        .err_wr_data(err_wr_data),
        .irq_en     (irq_en),
        .rd_data    (rd_data),
        .flags      (flags),
        .irq        (irq)
    );

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_master,
    input logic       wr_en,
    input logic       rd_en,
    input logic       err_wr_en,
    input logic [2:0] irq_en,
    input logic       busy,
    input logic [2:0] flags,
    input logic       irq,
    input logic       sck_o,
    input logic       done
);
    AST_WCOL_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (rst)
        busy && wr_en |=> flags[2]); // R6
    AST_COLLIDE_KEEPS_XFER: assert property (@(posedge clk) disable iff (rst)
        busy && wr_en && !done && cfg_master |=> busy); // R6
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        done && flags[0] && !rd_en |=> flags[1]); // R5
    AST_READ_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done && rd_en && !flags[1] && !err_wr_en |=> !flags[1]); // R5
    AST_RX_FULL_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> flags[0]); // R4
    AST_ROVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags[1] && !err_wr_en |=> flags[1]); // R7
    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags[2] && !err_wr_en |=> flags[2]); // R7
    AST_IRQ_ON_ROVR: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) && irq_en[1] |-> irq); // R8
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck_o); // R9
endmodule

bind spi_xfer_engine spi_xfer_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_master(cfg_master),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .err_wr_en (err_wr_en),
    .irq_en    (irq_en),
    .busy      (busy),
    .flags     (flags),
    .irq       (irq),
    .sck_o     (sck_o),
    .done      (xfer_done)
);

// File: tb/spi_xfer_engine_bench.sv
`timescale 1ns/1ps
module spi_xfer_engine_bench;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_master = 1'b1, cfg_wide = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, err_wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  err_wr_data = '0;
    logic [2:0]  irq_en = '0;
    logic        sck_i = 1'b0, sel_n_i = 1'b1, spi_din = 1'b0;
    logic [15:0] rd_data;
    logic [2:0]  flags;
    logic        busy, irq, sck_o, spi_dout;

    int total = 0;
    int bad   = 0;
    int pulses = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge sck_o) pulses++;

    spi_xfer_engine #(.SCK_DIV(DIV)) u_spi_xfer_engine (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .err_wr_en(err_wr_en), .err_wr_data(err_wr_data), .irq_en(irq_en),
        .busy(busy), .flags(flags), .irq(irq), .sck_o(sck_o), .sck_i(sck_i),
        .sel_n_i(sel_n_i), .spi_din(spi_din), .spi_dout(spi_dout)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic read_buf();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic err_write(input logic [1:0] v);
        @(negedge clk) begin err_wr_en = 1'b1; err_wr_data = v; end
        @(negedge clk) err_wr_en = 1'b0;
    endtask

    // master transfer with a bench-side peer; optional read in the completion cycle
    task automatic m_xfer(input logic [15:0] wdata, input logic [15:0] pat,
                          input bit read_at_done, output logic [15:0] mosi_cap,
                          output logic [15:0] old_rd, output logic busy_seen);
        int n = cfg_wide ? 16 : 8;
        mosi_cap = '0;
        old_rd   = '0;
        pulses   = 0;
        @(negedge clk);
        spi_din = pat[n-1];
        wr_en = 1'b1; wr_data = wdata;
        @(negedge clk) wr_en = 1'b0;
        busy_seen = busy;
        for (int i = 0; i < n; i++) begin
            @(posedge sck_o);
            mosi_cap = {mosi_cap[14:0], spi_dout};
            if (i == n - 1) begin
                if (read_at_done) begin
                    repeat (DIV - 1) @(posedge clk);
                    @(negedge clk) begin rd_en = 1'b1; old_rd = rd_data; end
                    @(negedge clk) rd_en = 1'b0;
                end
            end else begin
                @(negedge sck_o);
                spi_din = pat[n-2-i];
            end
        end
        wait_idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11", "busy", busy, 0);
        check("R11", "flags", flags, 0);
        check("R11", "irq", irq, 0);
        check("R11", "sck_o", sck_o, 0);
        check("R11", "rd_data", rd_data, 0);
    endtask

    task automatic t_master8();
        logic [15:0] cap, old; logic bs;
        cfg_master = 1'b1; cfg_wide = 1'b0;
        m_xfer(16'hA53C, 16'h0096, 0, cap, old, bs);
        check("R9", "busy after write", bs, 1);
        check("R1", "8-bit pulse count", pulses, 8);
        check("R2", "tx low byte only", cap[7:0], 8'h3C);
        check("R3", "rx right-justified", rd_data, 16'h0096);
        check("R4", "buffer full", flags[0], 1);
        check("R9", "idle after done", {busy, sck_o}, 2'b00);
    endtask

    task automatic t_master16();
        logic [15:0] cap, old; logic bs;
        read_buf();
        check("R4", "read clears full", flags[0], 0);
        cfg_wide = 1'b1;
        m_xfer(16'hC3A5, 16'h5AF0, 0, cap, old, bs);
        check("R1", "16-bit pulse count", pulses, 16);
        check("R1", "16-bit tx", cap, 16'hC3A5);
        check("R1", "16-bit rx", rd_data, 16'h5AF0);
    endtask

    task automatic t_overrun();
        logic [15:0] cap, old; logic bs;
        cfg_wide = 1'b0; irq_en = 3'b010;
        m_xfer(16'h0000, 16'hFF11, 0, cap, old, bs);
        check("R5", "overrun set", flags[1], 1);
        check("R5", "newest kept", rd_data, 16'h0011);
        check("R8", "irq from overrun", irq, 1);
        repeat (10) @(negedge clk);
        check("R7", "overrun sticky", flags[1], 1);
        err_write(2'b00);
        check("R7", "overrun cleared by write", flags[1], 0);
        check("R8", "irq drops", irq, 0);
    endtask

    task automatic t_same_cycle_read();
        logic [15:0] cap, old; logic bs;
        check("R5", "buffer still full", flags[0], 1);
        m_xfer(16'h0000, 16'h0077, 1, cap, old, bs);
        check("R5", "read returns old", old, 16'h0011);
        check("R5", "new stored", rd_data, 16'h0077);
        check("R5", "no overrun on same-cycle read", flags[1], 0);
        check("R4", "full after same-cycle read", flags[0], 1);
    endtask

    task automatic t_collision();
        logic [15:0] cap;
        int t = 0;
        read_buf();
        cfg_wide = 1'b0; irq_en = 3'b100; pulses = 0; cap = '0;
        spi_din = 1'b0;
        @(negedge clk) begin wr_en = 1'b1; wr_data = 16'h005A; end
        @(negedge clk) wr_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(posedge sck_o);
            cap = {cap[14:0], spi_dout};
            if (i == 3) begin
                @(negedge clk) begin wr_en = 1'b1; wr_data = 16'hFFFF; end
                @(negedge clk) wr_en = 1'b0;
                check("R6", "busy kept", busy, 1);
                check("R6", "collision flag", flags[2], 1);
                check("R8", "irq from collision", irq, 1);
            end
        end
        wait_idle();
        while (t < 10) begin @(negedge clk); t++; end
        check("R6", "transfer unchanged", cap[7:0], 8'h5A);
        check("R6", "pulses unchanged", pulses, 8);
        err_write(2'b01);
        check("R7", "sw set overrun", flags[1], 1);
        check("R7", "sw clear collision", flags[2], 0);
        irq_en = 3'b010;
        #1 check("R8", "irq from sw-set flag", irq, 1);
        irq_en = 3'b000;
        #1 check("R8", "irq masked", irq, 0);
        err_write(2'b00);
    endtask

    task automatic t_slave();
        logic [15:0] cap = '0;
        logic [7:0]  pat = 8'hC9;
        read_buf();
        cfg_master = 1'b0; cfg_wide = 1'b0;
        @(negedge clk) sel_n_i = 1'b0;
        repeat (8) @(negedge clk);
        check("R10", "busy on select", busy, 1);
        for (int i = 0; i < 8; i++) begin
            spi_din = pat[7-i];
            repeat (8) @(negedge clk);
            cap = {cap[14:0], spi_dout};
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        check("R10", "slave rx", rd_data, 16'h00C9);
        check("R6", "slave sends staged word, not rejected", cap[7:0], 8'h5A);
        check("R10", "slave done", busy, 0);
        sel_n_i = 1'b1;
        repeat (8) @(negedge clk);
        // early deselect abandons the character
        read_buf();
        @(negedge clk) sel_n_i = 1'b0;
        repeat (8) @(negedge clk);
        sck_i = 1'b1; repeat (8) @(negedge clk);
        sck_i = 1'b0; repeat (8) @(negedge clk);
        sel_n_i = 1'b1;
        repeat (8) @(negedge clk);
        check("R10", "abort clears busy", busy, 0);
        check("R10", "abort stores nothing", flags[0], 0);
        cfg_master = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_master8();
        t_master16();
        t_overrun();
        t_same_cycle_read();
        t_collision();
        t_slave();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule